// File: doc/BRIEF.md
# Banked GPIO register controller

This block is the register side of a general-purpose I/O controller. A simple 32-bit register bus writes and reads a set of per-bank registers. Each bank covers a group of pins and has a data register and a direction register. A data write loads the output latches. A data read returns a mix of two sources. For pins configured as outputs it returns the latch. For pins configured as inputs it returns the pin level after a two-flop synchronizer.

The same address window holds four interrupt configuration registers at fixed word addresses. Those addresses form a hole in the bank map, and the bank map skips over it. The filtering logic, the pads and the tristate buffers are outside this block. Towards them, the block drives output-value and output-enable vectors and receives an input-value vector.

Reads return data one cycle after the request. All configuration can be read back, so software can save it and restore it later.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is all 0, every data and interrupt register reads 0, and each direction register reads 1 for every pin present in its bank.
- R2: Bank n has its base at (n+1)*8. If that value is 0x90 or higher, 0x10 is added to it. The data register sits at base+0 and the direction register at base+4. A write to one bank changes no other bank.
- R3: A direction bit of 1 makes the pin an input (pin_oe low). A direction bit of 0 makes it an output (pin_oe high). The change is visible on pin_oe in the cycle after the write.
- R4: A data write updates pin_out in the cycle after the write, whatever the pin's direction.
- R5: A data read returns, per bit, the output latch for output pins and the synchronized pin_in level for input pins. A pin_in change becomes readable two clock edges after it is first sampled.
- R6: The interrupt enable register at 0x90, the mode register at 0x94 and the filter enable register at 0x98 each hold IRQ_LINES bits. The filter cycle register at 0x9C holds FLT_CYC_W bits. All four can be written and read back.
- R7: bus_rdata carries the read value in the cycle after bus_rd is high, and is 0 in every other cycle.
- R8: In bank registers, bits at and above PINS_PER_BANK read 0 and ignore writes. Bits for pins beyond PIN_COUNT in the last bank also read 0 and ignore writes. Bits above each interrupt register's width read 0.
- R9: An unmapped address reads 0, and a write to it changes no state. Unmapped addresses include 0x00–0x07, any address with a nonzero low two bits, and any address above the last bank.
- R10: When a read and a write to the same register happen in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | PIN_COUNT | Pin levels from the pads, asynchronous |
| pin_out | output | PIN_COUNT | Output latch values |
| pin_oe | output | PIN_COUNT | Output enables, 1 = drive |

## Verification
The bench works the addresses on both sides of the interrupt hole. It writes bank 16 at 0x88 and bank 17 at 0xA0 and writes the 0x90 window between them. A design that did not skip the hole would corrupt an interrupt register or a bank.

It reads the partial last bank. A design that failed to mask the missing pins would return stray ones from the direction reset or from all-ones writes.

It changes a pin and reads it at once, then reads it again. A synchronizer one stage short or one stage long shows up as the wrong value in one of those two reads.

It also writes misaligned and out-of-range addresses. A loose address decode would alias those writes onto real registers. Finally, it issues a read and a write to the same register in one cycle, where a bypass would leak the new value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_W       = 32;
  localparam int unsigned BANK_STRIDE = 8;
  localparam int unsigned DIR_OFS     = 4;
  localparam int unsigned HOLE_LO     = 'h90;
  localparam int unsigned HOLE_SPAN   = 'h10;

  // Interrupt configuration block sits at HOLE_LO; word index selects register
  typedef enum logic [1:0] {
    CFG_EN   = 2'd0,
    CFG_MODE = 2'd1,
    CFG_FLT  = 2'd2,
    CFG_CYC  = 2'd3
  } irq_cfg_e;

  // Byte address of the data register of a bank, skipping the config hole
  function automatic int unsigned bank_base(input int unsigned bank);
    int unsigned a;
    a = (bank + 1) * BANK_STRIDE;
    if (a >= HOLE_LO) a = a + HOLE_SPAN;
    return a;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [LANES-1:0] wdata,
  input  logic [LANES-1:0] pin_sync,
  output logic [LANES-1:0] out_q,
  output logic [LANES-1:0] oe,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] rd_dir
);
  // dir: 1 = input, 0 = output
  logic [LANES-1:0] dir_q;
  logic [LANES-1:0] out_d;
  logic [LANES-1:0] dir_d;
  logic [LANES-1:0] mixed;

  always_comb begin
    out_d = wdata;
    dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (data_we) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_we) dir_q <= dir_d;
  end

  always_comb begin
    mixed = (dir_q & pin_sync) | (~dir_q & out_q);
    rd_data = '0;
    rd_dir  = '0;
    rd_data[LANES-1:0] = mixed;
    rd_dir[LANES-1:0]  = dir_q;
  end

  assign oe = ~dir_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 24,
  parameter int unsigned CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  irq_cfg_e         sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rd_val
);
  logic [LINES-1:0] en_q, mode_q, flt_q;
  logic [CYC_W-1:0] cyc_q;
  logic [LINES-1:0] line_d;
  logic [CYC_W-1:0] cyc_d;
  logic             en_we, mode_we, flt_we, cyc_we;

  always_comb begin
    line_d  = wdata[LINES-1:0];
    cyc_d   = wdata[CYC_W-1:0];
    en_we   = we && (sel == CFG_EN);
    mode_we = we && (sel == CFG_MODE);
    flt_we  = we && (sel == CFG_FLT);
    cyc_we  = we && (sel == CFG_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flt_q <= '0;
    else if (flt_we) flt_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cyc_we) cyc_q <= cyc_d;
  end

  always_comb begin
    rd_val = '0;
    unique case (sel)
      CFG_EN:   rd_val[LINES-1:0] = en_q;
      CFG_MODE: rd_val[LINES-1:0] = mode_q;
      CFG_FLT:  rd_val[LINES-1:0] = flt_q;
      CFG_CYC:  rd_val[CYC_W-1:0] = cyc_q;
      default:  rd_val = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT     = 140,
  parameter int unsigned PINS_PER_BANK = 8,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned IRQ_LINES     = 24,
  parameter int unsigned FLT_CYC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  localparam int unsigned NUM_BANKS = (PIN_COUNT + PINS_PER_BANK - 1) / PINS_PER_BANK;
  localparam int unsigned CFG_WORD  = HOLE_LO >> 4;

  logic                 rst_int_n;
  logic [PIN_COUNT-1:0] pin_sync;
  logic [31:0]          addr_ext;
  logic                 cfg_hit;
  irq_cfg_e             cfg_sel;
  logic [BUS_W-1:0]     cfg_rd;
  logic [PINS_PER_BANK-1:0] bank_rd [NUM_BANKS];
  logic [PINS_PER_BANK-1:0] bank_or;
  logic [BUS_W-1:0]     rdata_d;
  logic [BUS_W-1:0]     rdata_q;

  gpio_rst_sync u_rst_sync (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_out (rst_int_n)
  );

  gpio_in_sync #(.W(PIN_COUNT)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  assign addr_ext = 32'(bus_addr);
  assign cfg_hit  = (addr_ext[31:4] == 28'(CFG_WORD)) && (addr_ext[1:0] == 2'b00);
  assign cfg_sel  = irq_cfg_e'(addr_ext[3:2]);

  gpio_irq_cfg #(.LINES(IRQ_LINES), .CYC_W(FLT_CYC_W)) u_irq_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (bus_wr && cfg_hit),
    .sel    (cfg_sel),
    .wdata  (bus_wdata),
    .rd_val (cfg_rd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE  = bank_base(b);
    localparam int unsigned FIRST = b * PINS_PER_BANK;
    localparam int unsigned LANES = ((PIN_COUNT - FIRST) >= PINS_PER_BANK) ?
                                    PINS_PER_BANK : (PIN_COUNT - FIRST);
    logic                     hit_data;
    logic                     hit_dir;
    logic [PINS_PER_BANK-1:0] rd_data;
    logic [PINS_PER_BANK-1:0] rd_dir;

    assign hit_data = (addr_ext == BASE);
    assign hit_dir  = (addr_ext == BASE + DIR_OFS);

    gpio_bank_slice #(.WIDTH(PINS_PER_BANK), .LANES(LANES)) u_slice (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .data_we  (bus_wr && hit_data),
      .dir_we   (bus_wr && hit_dir),
      .wdata    (bus_wdata[LANES-1:0]),
      .pin_sync (pin_sync[FIRST +: LANES]),
      .out_q    (pin_out[FIRST +: LANES]),
      .oe       (pin_oe[FIRST +: LANES]),
      .rd_data  (rd_data),
      .rd_dir   (rd_dir)
    );

    assign bank_rd[b] = ({PINS_PER_BANK{hit_data}} & rd_data) |
                        ({PINS_PER_BANK{hit_dir}}  & rd_dir);
  end

  always_comb begin
    bank_or = '0;
    for (int b = 0; b < NUM_BANKS; b++) bank_or = bank_or | bank_rd[b];
  end

  // Next-state for read data: value only in the cycle after a request
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      rdata_d[PINS_PER_BANK-1:0] = bank_or;
      if (cfg_hit) rdata_d = rdata_d | cfg_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT     = 140,
  parameter int unsigned PINS_PER_BANK = 8,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned IRQ_LINES     = 24,
  parameter int unsigned FLT_CYC_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] pin_oe
);
  localparam int unsigned NUM_BANKS = (PIN_COUNT + PINS_PER_BANK - 1) / PINS_PER_BANK;
  localparam int unsigned W_A = (PINS_PER_BANK > IRQ_LINES) ? PINS_PER_BANK : IRQ_LINES;
  localparam int unsigned RD_TOP = (W_A > FLT_CYC_W) ? W_A : FLT_CYC_W;

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic [31:0] ai;
    ai = 32'(a);
    if (ai[1:0] != 2'b00) return 1'b0;
    if (ai >= HOLE_LO && ai < HOLE_LO + HOLE_SPAN) return 1'b1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (ai == bank_base(b) || ai == bank_base(b) + DIR_OFS) return 1'b1;
    return 1'b0;
  endfunction

  // R7: read data is zero unless a read was requested the cycle before
  assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == 32'h0));

  // R3: output enables only move after a write
  assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(pin_oe));

  // R4: output latches only move after a write
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(pin_out));

  // R9: writes to unmapped addresses leave the pins alone
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_mapped(bus_addr)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9: reads of unmapped addresses return zero
  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_addr)) |=> (bus_rdata == 32'h0));

  if (RD_TOP < 32) begin : g_top_bits
    // R8: bits above every register width read as zero
    assert_rdata_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:RD_TOP] == '0);
  end
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .PIN_COUNT     (PIN_COUNT),
  .PINS_PER_BANK (PINS_PER_BANK),
  .ADDR_W        (ADDR_W),
  .IRQ_LINES     (IRQ_LINES),
  .FLT_CYC_W     (FLT_CYC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 140;
  localparam int PPB  = 8;
  localparam int NBK  = (PINS + PPB - 1) / PPB;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [PINS-1:0] m_out, m_dir, m_s1, m_s2;
  logic [23:0]     m_ien, m_imode, m_fen;
  logic [7:0]      m_fcyc;
  logic [31:0]     m_rdata;

  function automatic int base_of(int b);
    int a;
    a = (b + 1) * 8;
    if (a >= 'h90) a += 'h10;
    return a;
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r;
    r = 32'h0;
    if (a == 'h90) r = {8'h0, m_ien};
    if (a == 'h94) r = {8'h0, m_imode};
    if (a == 'h98) r = {8'h0, m_fen};
    if (a == 'h9C) r = {24'h0, m_fcyc};
    for (int b = 0; b < NBK; b++)
      for (int i = 0; i < PPB; i++) begin
        int p;
        p = b * PPB + i;
        if (p < PINS) begin
          if (a == base_of(b))     r[i] = m_dir[p] ? m_s2[p] : m_out[p];
          if (a == base_of(b) + 4) r[i] = m_dir[p];
        end
      end
    return r;
  endfunction

  task automatic m_write(int a, logic [31:0] d);
    if (a == 'h90) m_ien   = d[23:0];
    if (a == 'h94) m_imode = d[23:0];
    if (a == 'h98) m_fen   = d[23:0];
    if (a == 'h9C) m_fcyc  = d[7:0];
    for (int b = 0; b < NBK; b++)
      for (int i = 0; i < PPB; i++) begin
        int p;
        p = b * PPB + i;
        if (p < PINS) begin
          if (a == base_of(b))     m_out[p] = d[i];
          if (a == base_of(b) + 4) m_dir[p] = d[i];
        end
      end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '1; m_s1 = '0; m_s2 = '0;
      m_ien = '0; m_imode = '0; m_fen = '0; m_fcyc = '0; m_rdata = '0;
    end else begin
      int a;
      a = int'(bus_addr);
      m_rdata = bus_rd ? m_read(a) : 32'h0;
      if (bus_wr) m_write(a, bus_wdata);
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (bus_rdata !== m_rdata || pin_out !== m_out || pin_oe !== ~m_dir) begin
        mismatched++;
        $display("FAIL %s: rdata=%h out=%h oe=%h expected rdata=%h out=%h oe=%h",
                 phase, bus_rdata, pin_out, pin_oe, m_rdata, m_out, ~m_dir);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string tag, int a, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected completion earlier", n);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R1";
    chk("R1 pin_oe", 32'(pin_oe == '0), 32'h1);
    chk("R1 pin_out", 32'(pin_out == '0), 32'h1);
    rd_check("R1 dir bank0", 'h0C, 32'hFF);
    rd_check("R1 data bank0", 'h08, 32'h0);
    rd_check("R1 irq enable", 'h90, 32'h0);
    rd_check("R8 dir last bank", 'hA4, 32'h0F);

    phase = "R3";
    wr('h0C, 32'h0F);
    chk("R3 oe bank0", 32'(pin_oe[7:0]), 32'hF0);

    phase = "R4";
    wr('h08, 32'hA5);
    chk("R4 out bank0", 32'(pin_out[7:0]), 32'hA5);

    phase = "R5";
    pin_in[7:0] = 8'h3C;
    repeat (3) @(negedge clk);
    rd_check("R5 mixed read", 'h08, 32'hAC);
    pin_in[7:0] = 8'h33;
    rd_check("R5 sync latency old", 'h08, 32'hAC);
    rd_check("R5 sync latency new", 'h08, 32'hA3);

    phase = "R2";
    wr('h88, 32'h3C);
    wr('h8C, 32'h00);
    chk("R2 out bank16", 32'(pin_out[135:128]), 32'h3C);
    chk("R2 oe bank16", 32'(pin_oe[135:128]), 32'hFF);
    rd_check("R2 data bank16", 'h88, 32'h3C);
    wr('hA0, 32'h0A);
    chk("R4 out bank17 as input", 32'(pin_out[139:136]), 32'hA);
    rd_check("R2 data bank17 input", 'hA0, 32'h0);

    phase = "R6";
    wr('h90, 32'h0012_3456);
    rd_check("R6 enable", 'h90, 32'h0012_3456);
    rd_check("R2 bank16 kept", 'h88, 32'h3C);
    wr('h94, 32'hFFFF_FFFF);
    rd_check("R6 mode", 'h94, 32'h00FF_FFFF);
    wr('h98, 32'h00AA_AAAA);
    rd_check("R6 filter enable", 'h98, 32'h00AA_AAAA);
    wr('h9C, 32'h0000_01FF);
    rd_check("R6 filter cycle", 'h9C, 32'h0000_00FF);

    phase = "R8";
    wr('hA4, 32'h0);
    wr('hA0, 32'hFFFF_FFFF);
    rd_check("R8 last bank data", 'hA0, 32'h0F);
    chk("R8 out last bank", 32'(pin_out[139:136]), 32'hF);
    rd_check("R8 last bank dir", 'hA4, 32'h0);
    wr('h08, 32'hFFFF_FF00);
    rd_check("R8 upper bits ignored", 'h08, 32'h03);

    phase = "R9";
    wr('h00, 32'hFF);
    wr('h04, 32'hFF);
    wr('h0D, 32'hFF);
    wr('hA8, 32'hFF);
    wr('hFC, 32'hFF);
    rd_check("R9 read 0x00", 'h00, 32'h0);
    rd_check("R9 read 0x0D", 'h0D, 32'h0);
    rd_check("R9 read 0xA8", 'hA8, 32'h0);
    rd_check("R9 dir bank0 kept", 'h0C, 32'h0F);
    rd_check("R9 data bank0 kept", 'h08, 32'h03);

    phase = "R10";
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = AW'('h88); bus_wdata = 32'h55;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 read before write", bus_rdata, 32'h3C);
    rd_check("R10 new value", 'h88, 32'h55);

    phase = "R7";
    for (int k = 0; k < 400; k++) begin
      int a;
      case ($urandom_range(0, 3))
        0:       a = base_of($urandom_range(0, NBK - 1));
        1:       a = base_of($urandom_range(0, NBK - 1)) + 4;
        2:       a = 'h90 + 4 * $urandom_range(0, 3);
        default: a = $urandom_range(0, 255);
      endcase
      @(negedge clk);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_rd    = ($urandom_range(0, 1) == 0);
      bus_addr  = AW'(a);
      bus_wdata = $urandom;
      for (int w = 0; w < PINS; w += 32) pin_in = (pin_in << 32) | PINS'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule